// File: doc/BRIEF.md
# GPIO Port Pin Multiplexer

This block owns sixteen pads of a general-purpose port. For every pad it decides who drives it: the plain GPIO logic, with its own data and direction registers, or one of four peripheral functions. A per-pin function-enable bit chooses between the two. When that bit is set, a two-bit select field for the pin names the peripheral whose output value and output enable go to the pad.

Software reaches the block through a plain single-cycle register port. The port has no valid/ready handshake and no back-pressure, because every write is accepted in the cycle it is presented. Reads are combinational on the address. Each pad input is fanned out, unregistered, to the peripheral input taps. A two-flop synchroniser also carries it to a read-only GPIO input register.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset every writable register reads 0, so all pins are GPIO inputs with `pad_oe` and `pad_out` at 0.
- R2: With a pin's function-enable bit at 0, its `pad_out` equals its data-out bit and its `pad_oe` equals its direction bit, whatever value its select field holds.
- R3: With a pin's function-enable bit at 1, the pin's select field picks the owner: 0 is function 0, 1 is function 1, 2 is function 2 and 3 is function 3. For pin n, `pad_out` = `per_out[f*16+n]` and `pad_oe` = `per_oe[f*16+n]`, where f is the selected function.
- R4: Pin n's select field sits at bits 2n+1:2n of the select register, at address 1. All 32 bits are writable and read back unchanged. As an example, writing 0x00000100 gives pin 4 function 1.
- R5: The function-enable register is at address 0 and holds bit n for pin n. Writes keep only bits 15:0, and bits 31:16 read as 0.
- R6: `tap_in` equals `pad_in` in the same cycle, at all times, including during reset, with no configuration.
- R7: The GPIO input register is read-only, at address 4. It shows `pad_in` delayed by two rising clock edges.
- R8: A write to address 4 or to an unmapped address (5 to 7) changes no register. Unmapped addresses read as 0.
- R9: A write to a register at a clock edge takes effect on `pad_out`, `pad_oe` and `reg_rdata` right after that edge. Data-out is at address 2 and direction is at address 3, each holding bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, full word |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 16 | Pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| per_out | input | 64 | Peripheral output values, function f pin n at bit f*16+n |
| per_oe | input | 64 | Peripheral output enables, same packing |
| tap_in | output | 16 | Peripheral input taps |

## Verification
A pad input can change in the same cycle as a register write that moves the same pin between GPIO and peripheral ownership. The bench provokes this by changing `pad_in` and writing the function-enable register at one falling edge. Right after the next rising edge it expects three things at once: the taps already show the new pad values, the pad is routed from the newly selected owner, and the input register still holds the old value. The new value must appear only after the second edge.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FEN  = 3'd0,
    A_MUX  = 3'd1,
    A_DOUT = 3'd2,
    A_DIR  = 3'd3,
    A_PIN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pinmux_sync.sv
`timescale 1ns/1ps
module pinmux_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pinmux_regs.sv
`timescale 1ns/1ps
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned MUX_W = PINS * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   pin_sync,
  output logic [DATA_W-1:0] rdata,
  output logic [PINS-1:0]   fen,
  output logic [MUX_W-1:0]  mux,
  output logic [PINS-1:0]   dout,
  output logic [PINS-1:0]   dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen  <= '0;
      mux  <= '0;
      dout <= '0;
      dir  <= '0;
    end else if (we) begin
      case (addr)
        A_FEN:   fen  <= wdata[PINS-1:0];
        A_MUX:   mux  <= wdata[MUX_W-1:0];
        A_DOUT:  dout <= wdata[PINS-1:0];
        A_DIR:   dir  <= wdata[PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_FEN:   rdata = DATA_W'(fen);
      A_MUX:   rdata = DATA_W'(mux);
      A_DOUT:  rdata = DATA_W'(dout);
      A_DIR:   rdata = DATA_W'(dir);
      A_PIN:   rdata = DATA_W'(pin_sync);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinmux_route.sv
`timescale 1ns/1ps
module pinmux_route #(
  parameter int unsigned PINS  = 16,
  parameter int unsigned FUNCS = 4,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned MUX_W = PINS * SEL_W,
  localparam int unsigned PER_W = PINS * FUNCS
) (
  input  logic [PINS-1:0]  fen,
  input  logic [MUX_W-1:0] mux,
  input  logic [PINS-1:0]  dout,
  input  logic [PINS-1:0]  dir,
  input  logic [PER_W-1:0] per_out,
  input  logic [PER_W-1:0] per_oe,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [SEL_W-1:0] sel;
    logic [FUNCS-1:0] fo, fe;

    assign sel = mux[n*SEL_W +: SEL_W];

    for (genvar f = 0; f < FUNCS; f++) begin : g_fn
      assign fo[f] = per_out[f*PINS + n];
      assign fe[f] = per_oe[f*PINS + n];
    end

    assign pad_out[n] = fen[n] ? fo[sel] : dout[n];
    assign pad_oe[n]  = fen[n] ? fe[sel] : dir[n];
  end
endmodule

// File: rtl/gpio_pinmux.sv
`timescale 1ns/1ps
module gpio_pinmux
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned FUNCS  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned SEL_W = $clog2(FUNCS),
  localparam int unsigned MUX_W = PINS * SEL_W,
  localparam int unsigned PER_W = PINS * FUNCS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic [PER_W-1:0]  per_out,
  input  logic [PER_W-1:0]  per_oe,
  output logic [PINS-1:0]   tap_in
);
  logic [PINS-1:0]  fen_q, dout_q, dir_q, pin_s;
  logic [MUX_W-1:0] mux_q;

  // Input taps: raw pad values, no gating.
  assign tap_in = pad_in;

  pinmux_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  pinmux_regs #(.PINS(PINS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pin_sync(pin_s), .rdata(reg_rdata),
    .fen(fen_q), .mux(mux_q), .dout(dout_q), .dir(dir_q)
  );

  pinmux_route #(.PINS(PINS), .FUNCS(FUNCS), .SEL_W(SEL_W)) u_route (
    .fen(fen_q), .mux(mux_q), .dout(dout_q), .dir(dir_q),
    .per_out(per_out), .per_oe(per_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/pinmux_chk.sv
`timescale 1ns/1ps
module pinmux_chk
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned FUNCS  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [PINS-1:0]         pad_in,
  input logic [PINS-1:0]         pad_out,
  input logic [PINS-1:0]         pad_oe,
  input logic [PINS*FUNCS-1:0]   per_out,
  input logic [PINS*FUNCS-1:0]   per_oe,
  input logic [PINS-1:0]         tap_in,
  input logic [PINS-1:0]         fen,
  input logic [PINS*SEL_W-1:0]   mux,
  input logic [PINS-1:0]         dout,
  input logic [PINS-1:0]         dir
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  assert_reset_oe_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0))
    else $error("R1 pads active after reset");

  assert_gpio_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fen & (pad_oe ^ dir)) == '0) && ((~fen & (pad_out ^ dout)) == '0))
    else $error("R2 GPIO routing mismatch");

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assert_periph_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fen[n] |-> (pad_out[n] == per_out[int'(mux[n*SEL_W +: SEL_W])*PINS + n]
               && pad_oe[n]  == per_oe[int'(mux[n*SEL_W +: SEL_W])*PINS + n]))
      else $error("R3 peripheral routing mismatch");
  end

  assert_fen_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FEN) |-> (reg_rdata[DATA_W-1:PINS] == '0))
    else $error("R5 upper enable bits nonzero");

  assert_tap_R6: assert property (@(posedge clk) tap_in == pad_in)
    else $error("R6 tap differs from pad");

  assert_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2 && reg_addr == A_PIN) |-> (reg_rdata[PINS-1:0] == $past(pad_in, 2)))
    else $error("R7 input register latency");

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> (dir == $past(reg_wdata[PINS-1:0])))
    else $error("R9 direction write lost");
endmodule

bind gpio_pinmux pinmux_chk #(
  .PINS(PINS), .FUNCS(FUNCS), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
  .tap_in(tap_in), .fen(fen_q), .mux(mux_q), .dout(dout_q), .dir(dir_q)
);

// File: tb/gpio_pinmux_tb.sv
`timescale 1ns/1ps
module gpio_pinmux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe, tap_in;
  logic [63:0] per_out, per_oe;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign per_out = {16'hFF00, 16'h5555, 16'h3333, 16'h0F0F};
  assign per_oe  = {16'hCCCC, 16'hF0F0, 16'h00FF, 16'hFFFF};

  gpio_pinmux u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
    .tap_in(tap_in)
  );

  // {fen, mux, dout, dir}
  localparam logic [79:0] VEC [8] = '{
    {16'h0000, 32'hFFFF_FFFF, 16'h1234, 16'h00F0},
    {16'hFFFF, 32'h0000_0000, 16'h0000, 16'h0000},
    {16'hFFFF, 32'h5555_5555, 16'hFFFF, 16'hFFFF},
    {16'hFFFF, 32'hAAAA_AAAA, 16'h0000, 16'hFFFF},
    {16'hFFFF, 32'hFFFF_FFFF, 16'h0F0F, 16'h0000},
    {16'h00FF, 32'hE4E4_E4E4, 16'hA5A5, 16'hFF00},
    {16'h0010, 32'h0000_0100, 16'h0000, 16'h0000},
    {16'hFF00, 32'h1B1B_1B1B, 16'h0F0F, 16'h3C3C}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] model(input logic [15:0] fen, input logic [31:0] mux,
                                        input logic [15:0] dout, input logic [15:0] dir);
    logic [15:0] o, e;
    for (int n = 0; n < 16; n++) begin
      if (fen[n]) begin
        int f = int'(mux[2*n +: 2]);
        o[n] = per_out[f*16 + n];
        e[n] = per_oe[f*16 + n];
      end else begin
        o[n] = dout[n];
        e[n] = dir[n];
      end
    end
    return {e, o};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, exp;
    // R6 during reset
    pad_in = 16'hBEEF;
    #1;
    chk(tap_in == 16'hBEEF, "R6 tap in reset", 32'(tap_in), 32'hBEEF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), r);
      chk(r == 0, "R1 reset register", r, 0);
    end
    chk(pad_oe == 0 && pad_out == 0, "R1 pads idle", {pad_oe, pad_out}, 0);

    // Table of routing vectors (R2, R3, R4)
    foreach (VEC[i]) begin
      wr(3'd0, 32'(VEC[i][79:64]));
      wr(3'd1, VEC[i][63:32]);
      wr(3'd2, 32'(VEC[i][31:16]));
      wr(3'd3, 32'(VEC[i][15:0]));
      exp = model(VEC[i][79:64], VEC[i][63:32], VEC[i][31:16], VEC[i][15:0]);
      chk({pad_oe, pad_out} == exp, (VEC[i][79:64] == 0) ? "R2 GPIO route" : "R3 periph route",
          {pad_oe, pad_out}, exp);
      rd(3'd1, r);
      chk(r == VEC[i][63:32], "R4 select readback", r, VEC[i][63:32]);
    end
    // R4 example: pin 4 function 1 drives per_out bit 20
    wr(3'd0, 32'h0010); wr(3'd1, 32'h0000_0100); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    chk(pad_out[4] == per_out[20] && pad_oe[4] == per_oe[20], "R4 pin4 alt1",
        32'({pad_oe[4], pad_out[4]}), 32'({per_oe[20], per_out[20]}));

    // R5 upper enable bits
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, r);
    chk(r == 32'h0000_FFFF, "R5 enable width", r, 32'h0000_FFFF);

    // R7 synchroniser latency
    wr(3'd0, 32'h0);
    @(negedge clk);
    pad_in = 16'h1357;
    rd(3'd4, r);
    chk(r[15:0] == 16'hBEEF, "R7 before edges", r, 32'hBEEF);
    @(negedge clk); rd(3'd4, r);
    chk(r[15:0] == 16'hBEEF, "R7 after one edge", r, 32'hBEEF);
    @(negedge clk); rd(3'd4, r);
    chk(r[15:0] == 16'h1357, "R7 after two edges", r, 32'h1357);

    // R8 writes to read-only and unmapped addresses
    wr(3'd2, 32'h0000_A5A5);
    wr(3'd4, 32'h0000_FFFF);
    rd(3'd4, r);
    chk(r[15:0] == 16'h1357, "R8 input reg read-only", r, 32'h1357);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), r);
      chk(r == 0, "R8 unmapped reads zero", r, 0);
    end
    rd(3'd0, r); chk(r == 0, "R8 enable untouched", r, 0);
    rd(3'd1, r); chk(r == 32'h0000_0100, "R8 select untouched", r, 32'h100);
    rd(3'd2, r); chk(r == 32'h0000_A5A5, "R8 data untouched", r, 32'hA5A5);

    // R9 write visible right after its edge; concurrent pad change and ownership swap
    wr(3'd3, 32'h0000_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(pad_oe == 16'hFFFF && pad_out == 16'hA5A5, "R9 GPIO before swap", {pad_oe, pad_out}, 32'hFFFF_A5A5);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_FFFF;
    pad_in = 16'h2468;
    #0.5;
    chk(tap_in == 16'h2468, "R6 tap immediate", 32'(tap_in), 32'h2468);
    chk(pad_out == 16'hA5A5, "R9 no change before edge", 32'(pad_out), 32'hA5A5);
    @(negedge clk);
    reg_we = 1'b0;
    #0.5;
    chk(pad_out == 16'hFF00 && pad_oe == 16'hCCCC, "R9 swap after edge", {pad_oe, pad_out}, 32'hCCCC_FF00);
    rd(3'd4, r);
    chk(r[15:0] == 16'h1357, "R7 concurrent one edge", r, 32'h1357);
    @(negedge clk); rd(3'd4, r);
    chk(r[15:0] == 16'h2468, "R7 concurrent two edges", r, 32'h2468);
    chk(tap_in == 16'h2468, "R6 tap steady", 32'(tap_in), 32'h2468);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule